// File: doc/BRIEF.md
# Serial-bus configuration register slave

This block is a two-wire serial-bus slave, following the SMBus 2.0 byte protocol, that lets a host read and write a small file of 8-bit configuration registers. The clock and data lines are sampled on the system clock. Each line passes through a two-stage synchronizer and a short stability filter before its edges are decoded into start, stop and bit events. The slave drives the data line only low, through an output-enable that an external open-drain pad turns into a pull-down.

Four strap inputs set the low bits of the 7-bit slave address, so several instances can share one bus. A host writes one register by sending the slave address with the write bit, a register index and a data byte. A host reads one register by sending the slave address with the write bit and the register index, then a repeated start and the slave address with the read bit, then clocking in one byte and returning a NACK. The whole register image is also presented in parallel on `cfg_o`, where the surrounding logic uses it.

Each register has its own reset value. The file returns to those values on the system reset, on a soft-reset command written through the bus, and for as long as the enable input is low.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal binary 101 followed by `strap_i[3:0]` (address byte A0h plus `strap_i` shifted left by one). Otherwise it does not acknowledge, and it ignores the bus until the next START.
- R2: A write transaction (START, address with R/W=0, register index, data byte, STOP) has every byte acknowledged and stores the data byte in the indexed register.
- R3: A read transaction (address with R/W=0, register index, repeated START, address with R/W=1) returns the indexed register's content, MSB first, after the second address acknowledge.
- R4: After reset, registers 10h–17h hold 20h, registers 20h–27h hold 03h, register 30h holds 02h, and all other registers hold 00h.
- R5: Writing a byte with bit 0 set to register 00h restores every register to its R4 value. Bit 0 of register 00h always reads as 0.
- R6: While `enable_i` is low, every register holds its R4 value and the slave acknowledges nothing.
- R7: Indexes at or above DEPTH (64) are unmapped. Writes to them are acknowledged but change nothing, and reads of them return 00h.
- R8: If SCL stays low for more than TIMEOUT_CYC system clocks during a transaction, the slave returns to idle. Further bits are then neither acknowledged nor written until a new START.
- R9: `sda_oe_o` changes only while SCL is low, and it is 0 when the bus is idle.
- R10: `cfg_o[8*i+7:8*i]` carries the current value of register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Low holds the register file at its reset values and the slave silent |
| strap_i | input | 4 | Low four bits of the 7-bit slave address |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| cfg_o | output | DEPTH*8 | Parallel image of all registers |

## Verification
A table of transactions runs reads of each class of reset value (equalizer, drive level, global adjust, plain zero), a write followed by a read-back, an unmapped write and read, a foreign address, and a soft reset followed by reads. Together these separate address decoding, index latching, data return and default values. Directed sequences then change the strap pins, which shows that the old address goes dead and the new one answers. They drop the enable input in the middle of a configured state, and they stall SCL past the timeout between the index and the data byte. A stalled transaction must leave the register untouched, while an equally long transaction without the stall writes it.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    // Upper three bits of the 7-bit slave address; the straps fill the rest.
    localparam logic [2:0] DEV_BASE_HI = 3'b101;

    // Register layout: groups with non-zero reset values.
    localparam int NUM_LANES = 8;
    localparam int EQ_BASE   = 16;   // equalizer controls, 10h..17h
    localparam int DRV_BASE  = 32;   // drive-level controls, 20h..27h
    localparam int GADJ_IDX  = 48;   // global drive adjust, 30h

    typedef enum logic [2:0] {
        S_IDLE,   // nothing addressed to this slave
        S_DEV,    // shifting in the address byte
        S_REG,    // shifting in the register index
        S_WDAT,   // shifting in the write data
        S_ACK,    // holding the acknowledge low
        S_RDAT,   // shifting out read data
        S_RACK,   // master's acknowledge slot
        S_WAIT    // ignoring the bus until START or STOP
    } smb_state_e;

    typedef struct packed {
        logic lvl;    // filtered level
        logic rise;   // one-cycle pulse on 0->1
        logic fall;   // one-cycle pulse on 1->0
    } line_evt_t;

    typedef struct packed {
        logic       we;
        logic [7:0] addr;
        logic [7:0] data;
    } reg_wr_t;

    function automatic logic [7:0] reg_default(input int idx);
        if (idx >= EQ_BASE && idx < EQ_BASE + NUM_LANES)   return 8'h20;
        if (idx >= DRV_BASE && idx < DRV_BASE + NUM_LANES) return 8'h03;
        if (idx == GADJ_IDX)                               return 8'h02;
        return 8'h00;
    endfunction

endpackage

// File: rtl/smb_line_cond.sv
module smb_line_cond
    import smb_cfg_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      raw_i,
    output line_evt_t evt_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic          filt_q;
    logic          prev_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            filt_q <= 1'b1;
            prev_q <= 1'b1;
            cnt_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            prev_q <= filt_q;
            if (sync_q[1] == filt_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
                filt_q <= sync_q[1];
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign evt_o = '{lvl: filt_q, rise: filt_q & ~prev_q, fall: ~filt_q & prev_q};

    // R9: the filtered level only moves toward a value the synchronizer held
    a_r9_filter_follows: assert property (@(posedge clk) disable iff (rst)
        (filt_q != prev_q) |-> ($past(sync_q[1]) == filt_q));

endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
    import smb_cfg_pkg::*;
#(
    parameter int TIMEOUT_CYC = 3_125_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic [3:0] strap_i,
    input  line_evt_t  scl_i,
    input  line_evt_t  sda_i,
    input  logic [7:0] rd_data_i,
    output reg_wr_t    wr_o,
    output logic [7:0] ptr_o,
    output logic       sda_oe_o
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    smb_state_e    state_q, after_q;
    logic [3:0]    bit_q;
    logic [7:0]    sh_q, tx_q, ptr_q;
    logic [TW-1:0] lo_cnt_q;
    reg_wr_t       wr_q;

    logic start_ev, stop_ev, timeout_ev;
    assign start_ev   = sda_i.fall & scl_i.lvl;
    assign stop_ev    = sda_i.rise & scl_i.lvl;
    assign timeout_ev = (lo_cnt_q == TW'(TIMEOUT_CYC));

    // SCL-low watchdog, active only inside a transaction
    always_ff @(posedge clk) begin
        if (rst || !en_i || start_ev || scl_i.lvl || state_q == S_IDLE)
            lo_cnt_q <= '0;
        else if (!timeout_ev)
            lo_cnt_q <= lo_cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        wr_q.we <= 1'b0;
        if (rst || !en_i) begin
            state_q <= S_IDLE;
            after_q <= S_IDLE;
            bit_q   <= '0;
            sh_q    <= '0;
            tx_q    <= '0;
            ptr_q   <= '0;
            wr_q    <= '0;
        end else if (start_ev) begin
            state_q <= S_DEV;
            bit_q   <= '0;
        end else if (stop_ev || timeout_ev) begin
            state_q <= S_IDLE;
        end else begin
            unique case (state_q)
                S_DEV, S_REG, S_WDAT: begin
                    if (scl_i.rise) begin
                        sh_q  <= {sh_q[6:0], sda_i.lvl};
                        bit_q <= bit_q + 4'd1;
                    end else if (scl_i.fall && bit_q == 4'd8) begin
                        bit_q <= '0;
                        if (state_q == S_DEV) begin
                            if (sh_q[7:1] == {DEV_BASE_HI, strap_i}) begin
                                state_q <= S_ACK;
                                after_q <= sh_q[0] ? S_RDAT : S_REG;
                            end else begin
                                state_q <= S_WAIT;
                            end
                        end else if (state_q == S_REG) begin
                            ptr_q   <= sh_q;
                            state_q <= S_ACK;
                            after_q <= S_WDAT;
                        end else begin
                            wr_q    <= '{we: 1'b1, addr: ptr_q, data: sh_q};
                            state_q <= S_ACK;
                            after_q <= S_WAIT;
                        end
                    end
                end
                S_ACK: begin
                    if (scl_i.fall) begin
                        state_q <= after_q;
                        bit_q   <= '0;
                        tx_q    <= rd_data_i;
                    end
                end
                S_RDAT: begin
                    if (scl_i.fall) begin
                        if (bit_q == 4'd7) state_q <= S_RACK;
                        tx_q  <= {tx_q[6:0], 1'b0};
                        bit_q <= bit_q + 4'd1;
                    end
                end
                S_RACK: begin
                    if (scl_i.rise) state_q <= S_WAIT;
                end
                default: ;
            endcase
        end
    end

    assign sda_oe_o = (state_q == S_ACK) || (state_q == S_RDAT && !tx_q[7]);
    assign wr_o     = wr_q;
    assign ptr_o    = ptr_q;

    // R9: the data line is released while idle
    a_r9_idle_release: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE) |-> !sda_oe_o);
    // R9: the slave never moves SDA while SCL is high
    a_r9_change_scl_low: assert property (@(posedge clk) disable iff (rst)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_i.lvl);
    // R8: the low-time counter never passes its limit
    a_r8_counter_bound: assert property (@(posedge clk) disable iff (rst)
        lo_cnt_q <= TW'(TIMEOUT_CYC));
    // R8: an expiry sends the engine to idle
    a_r8_timeout_idle: assert property (@(posedge clk) disable iff (rst)
        (timeout_ev && !start_ev) |=> (state_q == S_IDLE));
    // R1: no acknowledge follows a foreign address
    a_r1_wait_silent: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WAIT) |-> !sda_oe_o);

endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
    import smb_cfg_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_i,
    input  reg_wr_t            wr_i,
    input  logic [7:0]         ptr_i,
    output logic [7:0]         rd_data_o,
    output logic [DEPTH*8-1:0] cfg_o
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0] regs_q [DEPTH];
    logic       soft_rst;

    assign soft_rst = wr_i.we && (wr_i.addr == 8'h00) && wr_i.data[0];

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst || !en_i || soft_rst)
                regs_q[g] <= reg_default(g);
            else if (wr_i.we && wr_i.addr == 8'(g))
                regs_q[g] <= (g == 0) ? {wr_i.data[7:1], 1'b0} : wr_i.data;
        end
        assign cfg_o[g*8 +: 8] = regs_q[g];
    end

    always_comb begin
        rd_data_o = 8'h00;
        if (32'(ptr_i) < DEPTH) rd_data_o = regs_q[ptr_i[IW-1:0]];
    end

    // R5: a soft-reset write restores the reset values
    a_r5_soft_restore: assert property (@(posedge clk) disable iff (rst || !en_i)
        soft_rst |=> (regs_q[DEPTH-1] == reg_default(DEPTH-1)));
    // R6: a low enable forces the reset values
    a_r6_enable_default: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (regs_q[DEPTH-1] == reg_default(DEPTH-1)));
    // R2: a write strobe lands in the addressed register
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst || !en_i)
        (wr_i.we && wr_i.addr == 8'(DEPTH-1)) |=> (regs_q[DEPTH-1] == $past(wr_i.data)));

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter int DEPTH       = 64,
    parameter int FILT_LEN    = 3,
    parameter int TIMEOUT_CYC = 3_125_000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable_i,
    input  logic [3:0]         strap_i,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    output logic [DEPTH*8-1:0] cfg_o
);
    line_evt_t  scl_evt, sda_evt;
    reg_wr_t    wr;
    logic [7:0] ptr, rd_data;

    smb_line_cond #(.FILT_LEN(FILT_LEN)) u_scl_cond (
        .clk(clk), .rst(rst), .raw_i(scl_i), .evt_o(scl_evt));

    smb_line_cond #(.FILT_LEN(FILT_LEN)) u_sda_cond (
        .clk(clk), .rst(rst), .raw_i(sda_i), .evt_o(sda_evt));

    smb_proto_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
        .clk(clk), .rst(rst), .en_i(enable_i), .strap_i(strap_i),
        .scl_i(scl_evt), .sda_i(sda_evt), .rd_data_i(rd_data),
        .wr_o(wr), .ptr_o(ptr), .sda_oe_o(sda_oe_o));

    smb_cfg_regs #(.DEPTH(DEPTH)) u_regs (
        .clk(clk), .rst(rst), .en_i(enable_i), .wr_i(wr), .ptr_i(ptr),
        .rd_data_o(rd_data), .cfg_o(cfg_o));

    // R6: a low enable silences the slave one cycle later
    a_r6_silent_disabled: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> !sda_oe_o);

endmodule

// File: tb/test_smb_cfg_slave.sv
module test_smb_cfg_slave;

    localparam int DEPTH = 64;
    localparam int TMO   = 400;
    localparam int Q     = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b1;
    logic [3:0] strap = 4'b0101;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [DEPTH*8-1:0] cfg;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;
    int r9_bad = 0;
    logic prev_oe = 1'b0;
    bit done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    smb_cfg_slave #(.DEPTH(DEPTH), .FILT_LEN(3), .TIMEOUT_CYC(TMO)) i_smb_cfg_slave (
        .clk(clk), .rst(rst), .enable_i(enable), .strap_i(strap),
        .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe), .cfg_o(cfg));

    // Expected reset value of a register, from R4
    function automatic logic [7:0] exp_default(input int i);
        if (i >= 8'h10 && i <= 8'h17) return 8'h20;
        if (i >= 8'h20 && i <= 8'h27) return 8'h03;
        if (i == 8'h30) return 8'h02;
        return 8'h00;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        tick(3); sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(3); sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        tick(3); sda_m = b; tick(Q);
        scl_m = 1'b1; tick(Q);
        s = sda_line; tick(Q);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(nack, s);
    endtask

    task automatic write_reg(input logic [6:0] dev, input logic [7:0] idx, input logic [7:0] d,
                             output logic a0, output logic a1, output logic a2);
        bus_start();
        send_byte({dev, 1'b0}, a0);
        send_byte(idx, a1);
        send_byte(d, a2);
        bus_stop();
    endtask

    task automatic read_reg(input logic [6:0] dev, input logic [7:0] idx,
                            output logic a0, output logic a1, output logic a2, output logic [7:0] d);
        bus_start();
        send_byte({dev, 1'b0}, a0);
        send_byte(idx, a1);
        bus_start();
        send_byte({dev, 1'b1}, a2);
        recv_byte(1'b1, d);
        bus_stop();
    endtask

    // Transaction table: read?, device, index, write data, expect ack, expect read data
    typedef struct packed {
        logic       rd;
        logic [6:0] dev;
        logic [7:0] idx;
        logic [7:0] wdata;
        logic       ack;
        logic [7:0] rdata;
    } vec_t;

    localparam logic [6:0] DEV = 7'h55;   // 101 + strap 0101 (R1)
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, DEV,   8'h10, 8'h00, 1'b1, 8'h20},  // R3 R4 equalizer default
        '{1'b1, DEV,   8'h27, 8'h00, 1'b1, 8'h03},  // R4 drive default
        '{1'b1, DEV,   8'h30, 8'h00, 1'b1, 8'h02},  // R4 global adjust default
        '{1'b1, DEV,   8'h05, 8'h00, 1'b1, 8'h00},  // R4 plain zero
        '{1'b0, DEV,   8'h11, 8'hA5, 1'b1, 8'h00},  // R2 write
        '{1'b1, DEV,   8'h11, 8'h00, 1'b1, 8'hA5},  // R3 read back
        '{1'b0, DEV,   8'h50, 8'h77, 1'b1, 8'h00},  // R7 unmapped write acked
        '{1'b1, DEV,   8'h50, 8'h00, 1'b1, 8'h00},  // R7 unmapped read zero
        '{1'b0, 7'h54, 8'h12, 8'h99, 1'b0, 8'h00},  // R1 foreign address
        '{1'b1, DEV,   8'h12, 8'h00, 1'b1, 8'h20},  // R1 foreign write had no effect
        '{1'b0, DEV,   8'h00, 8'h01, 1'b1, 8'h00},  // R5 soft reset
        '{1'b1, DEV,   8'h11, 8'h00, 1'b1, 8'h20},  // R5 register restored
        '{1'b1, DEV,   8'h00, 8'h00, 1'b1, 8'h00}   // R5 reset bit reads 0
    };

    // R9 monitor: the data line driver must not move while SCL is high
    always @(negedge clk) begin
        if (!rst && sda_oe !== prev_oe && scl_m) r9_bad++;
        prev_oe = sda_oe;
    end

    // Watchdog
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic a0, a1, a2;
        logic [7:0] d;
        int bad;

        tick(5);
        rst = 1'b0;
        tick(5);

        // R4 R10: reset image on cfg_o
        bad = 0;
        for (int i = 0; i < DEPTH; i++)
            if (cfg[i*8 +: 8] != exp_default(i)) bad++;
        chk("R4 R10 reset image mismatches", bad, 0);
        chk("R9 released after reset", sda_oe, 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            if (VECS[v].rd) begin
                read_reg(VECS[v].dev, VECS[v].idx, a0, a1, a2, d);
                chk($sformatf("R1 R3 vec%0d ack", v), {a0, a1, a2}, {3{VECS[v].ack}});
                if (VECS[v].ack) chk($sformatf("R3 vec%0d data", v), d, VECS[v].rdata);
            end else begin
                write_reg(VECS[v].dev, VECS[v].idx, VECS[v].wdata, a0, a1, a2);
                chk($sformatf("R1 R2 vec%0d ack", v), {a0, a1, a2}, {3{VECS[v].ack}});
            end
        end
        chk("R9 released after table", sda_oe, 0);

        // R10: a write appears on cfg_o
        write_reg(DEV, 8'h13, 8'h11, a0, a1, a2);
        chk("R10 cfg_o after write", cfg[8'h13*8 +: 8], 8'h11);

        // R6: enable low restores defaults and silences the slave
        enable = 1'b0;
        tick(5);
        chk("R6 default while disabled", cfg[8'h13*8 +: 8], 8'h20);
        write_reg(DEV, 8'h15, 8'h44, a0, a1, a2);
        chk("R6 no ack while disabled", {a0, a1, a2}, 0);
        chk("R6 no write while disabled", cfg[8'h15*8 +: 8], 8'h20);
        enable = 1'b1;
        tick(5);
        read_reg(DEV, 8'h13, a0, a1, a2, d);
        chk("R6 value after re-enable", d, 8'h20);

        // R1: new strap, new address
        strap = 4'b1000;
        tick(5);
        read_reg(7'h58, 8'h20, a0, a1, a2, d);
        chk("R1 new strap ack", {a0, a1, a2}, 3'b111);
        chk("R1 new strap data", d, 8'h03);
        write_reg(DEV, 8'h20, 8'h3C, a0, a1, a2);
        chk("R1 old address ignored", a0, 0);
        chk("R1 old address no write", cfg[8'h20*8 +: 8], 8'h03);

        // R8: SCL stalled past the timeout between index and data
        bus_start();
        send_byte({7'h58, 1'b0}, a0);
        send_byte(8'h14, a1);
        tick(TMO + 60);
        send_byte(8'h66, a2);
        bus_stop();
        chk("R8 header acked", {a0, a1}, 2'b11);
        chk("R8 data after timeout not acked", a2, 0);
        chk("R8 no write after timeout", cfg[8'h14*8 +: 8], 8'h20);
        write_reg(7'h58, 8'h14, 8'h66, a0, a1, a2);
        chk("R8 normal write still works", cfg[8'h14*8 +: 8], 8'h66);

        chk("R9 driver moved while SCL high", r9_bad, 0);
        chk("R9 released at end", sda_oe, 0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule